// File: doc/BRIEF.md
# Line-21 Closed Caption Waveform Encoder

This block builds the closed caption / extended data service packet that rides on one video line of each field. Control logic writes a pair of seven-bit characters for each field; the block adds an odd parity bit to each. On the selected line of each enabled field it sends the packet as a stream of digital luma level codes: seven run-in clock cycles, the three framing bits, then the two characters, least significant bit first. The bit rate is 32 times the line frequency. The bit clock comes from a phase accumulator running on the 27 MHz pixel-rate clock, so the bit period is a fraction of a clock: 53.625 clocks per bit for 525-line timing (1716 clocks per line) and 54 clocks per bit for 625-line timing (1728 clocks per line).

The line is counted from a field-start strobe, and its number is programmable. The packet begins a programmable number of clocks after the horizontal-sync strobe of that line. While the packet is on air an active flag tells the downstream luma mixer to take the level code in place of video. Outside the packet the level code is the blanking (0 IRE) code. A field whose pair was not rewritten since its last packet sends the null pair 0x80, 0x80.

Top module: `cc21_line21_enc`

## Requirements
- R1: While reset is asserted and right after it is released, `active_o` is 0 and `level_o` equals LOW_CODE (0 IRE, default 16).
- R2: A packet is sent only on the line whose count since the last `field_start_i` equals `line_sel_i`, and only if `field_en_i[f]` is 1 for the current field f. The first `line_start_i` after `field_start_i` is line 1; bit 0 of `field_en_i` enables field 0 and bit 1 enables field 1. Every other line keeps `active_o` at 0.
- R3: The first active cycle comes `delay_i`+1 clock cycles after the edge that samples the `line_start_i` strobe of the selected line.
- R4: Counting cycle t = 0 as the first active cycle, the cycle carries packet bit floor(32·t/N). N is 1716 when `mode50_i` = 0 and 1728 when `mode50_i` = 1. `active_o` stays 1 while that index is below 26 and then drops to 0.
- R5: Bits 0 to 6 are the run-in. Within each of these bits the level is HIGH_CODE while (32·t mod N) < N/2, and LOW_CODE for the rest of the bit.
- R6: Bits 7, 8 and 9 are the framing code, sent as 0, 0, 1. Bits 10 to 17 carry the first character, least significant bit first, and bits 18 to 25 carry the second in the same way. A 1 is sent as HIGH_CODE (about 50 IRE, default 126) and a 0 as LOW_CODE.
- R7: Bit 7 of each transmitted character is the odd parity of its bits 6:0. Bit 7 of `wr_byte0_i` and `wr_byte1_i` is ignored.
- R8: A write with `wr_en_i` = 1 stores the pair for field `wr_field_i`. That pair is sent in the next packet of that field. Any later packet of that field that comes without a new write sends 0x80, 0x80.
- R9: Whenever `active_o` is 0, `level_o` is LOW_CODE. While active, `level_o` is only ever LOW_CODE or HIGH_CODE.
- R10: Each field keeps its own pair. A pair written while its field is disabled stays pending until a packet of that field is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start_i | input | 1 | One-cycle strobe at the start of a field |
| field_id_i | input | 1 | Field identity (0 or 1), sampled with field_start_i |
| line_start_i | input | 1 | One-cycle strobe at the horizontal sync leading edge |
| mode50_i | input | 1 | 1 selects 1728 clocks per line, 0 selects 1716 |
| line_sel_i | input | LINE_W | Line number that carries the packet |
| delay_i | input | DLY_W | Clocks from the sync strobe to the packet start |
| field_en_i | input | 2 | Per-field enable, bit f for field f |
| wr_en_i | input | 1 | Write strobe for a character pair |
| wr_field_i | input | 1 | Field the written pair belongs to |
| wr_byte0_i | input | 8 | First character (bit 7 ignored) |
| wr_byte1_i | input | 8 | Second character (bit 7 ignored) |
| level_o | output | LEVEL_W | Luma level code to insert |
| active_o | output | 1 | Packet on air; mixer selects level_o |

## Verification
The bench rebuilds the whole packet for every clock cycle from the arithmetic 32·t/N. It compares the design cycle by cycle, in both line-length modes, with delays of 0, 10 and 200 and with line numbers 2, 3 and 21. An accumulator with an off-by-one wrap, or one that ignores the mode, makes the bits drift so that the late data bits land in the wrong cycles. A start counter that is off by one shifts the whole window by a clock. The bench also follows the fresh/consumed state of each field's pair. It uses characters whose written bit 7 is wrong, characters with an even and an odd number of ones, a pair repeated without a rewrite, and a pair written while its field was disabled. Each of these cases exposes a design that passes bit 7 through, resends stale data instead of the null pair, or drops a pending pair when its field is skipped.

// File: rtl/cc21_pkg.sv
package cc21_pkg;
  localparam int RUNIN_BITS   = 7;
  localparam int FRAMING_BITS = 3;
  localparam int CHAR_BITS    = 8;
  localparam int FRAME_BITS   = RUNIN_BITS + FRAMING_BITS + 2 * CHAR_BITS;
  localparam int DATA_POS     = RUNIN_BITS + FRAMING_BITS;

  // Seven data bits plus odd parity in bit 7.
  function automatic logic [CHAR_BITS-1:0] with_odd_parity(input logic [CHAR_BITS-1:0] raw);
    return {~(^raw[CHAR_BITS-2:0]), raw[CHAR_BITS-2:0]};
  endfunction

  // Whole packet as a bit vector, index = transmit order. Run-in positions
  // are zero here; the serializer draws them from the accumulator phase.
  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [CHAR_BITS-1:0] c0,
                                                       input logic [CHAR_BITS-1:0] c1);
    logic [FRAME_BITS-1:0] f;
    f = '0;
    f[DATA_POS-1] = 1'b1;
    f[DATA_POS +: CHAR_BITS] = c0;
    f[DATA_POS + CHAR_BITS +: CHAR_BITS] = c1;
    return f;
  endfunction

  // Accumulator step: returns next phase and whether a bit boundary passed.
  function automatic logic [16:0] acc_next(input logic [15:0] acc, input logic [15:0] step,
                                           input logic [15:0] period);
    logic [16:0] sum;
    sum = {1'b0, acc} + {1'b0, step};
    if (sum >= {1'b0, period}) return {1'b1, sum[15:0] - period};
    return {1'b0, sum[15:0]};
  endfunction
endpackage

// File: rtl/cc21_bit_timer.sv
module cc21_bit_timer #(
  parameter int ACC_W = 12,
  parameter int STEP  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [ACC_W-1:0] period_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             tick_o
);
  import cc21_pkg::*;
  logic [ACC_W-1:0] acc_q;
  logic [16:0]      nxt;

  always_comb begin
    nxt    = acc_next(16'(acc_q), 16'(STEP), 16'(period_i));
    tick_o = run_i && nxt[16];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (start_i) acc_q <= '0;
    else if (run_i)   acc_q <= nxt[ACC_W-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cc21_line_sched.sv
module cc21_line_sched #(
  parameter int LINE_W = 6,
  parameter int DLY_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start_i,
  input  logic              field_id_i,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_sel_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [1:0]        field_en_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              field_o
);
  logic [LINE_W-1:0] lcnt_q, lnext;
  logic [DLY_W-1:0]  dcnt_q;
  logic              fld_q, armed_q, hit;

  always_comb begin
    lnext = (lcnt_q == {LINE_W{1'b1}}) ? lcnt_q : lcnt_q + 1'b1;
    hit   = line_start_i && !field_start_i && (lnext == line_sel_i)
            && field_en_i[fld_q] && !busy_i && !armed_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt_q <= '0;
      fld_q  <= 1'b0;
    end else if (field_start_i) begin
      lcnt_q <= '0;
      fld_q  <= field_id_i;
    end else if (line_start_i) begin
      lcnt_q <= lnext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dcnt_q  <= '0;
    end else if (hit) begin
      armed_q <= 1'b1;
      dcnt_q  <= delay_i;
    end else if (armed_q) begin
      if (dcnt_q == '0) armed_q <= 1'b0;
      else              dcnt_q  <= dcnt_q - 1'b1;
    end
  end

  assign start_o = armed_q && (dcnt_q == '0);
  assign field_o = fld_q;
endmodule

// File: rtl/cc21_serializer.sv
module cc21_serializer
  import cc21_pkg::*;
#(
  parameter int ACC_W = 12,
  parameter int IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  tick_i,
  input  logic [ACC_W-1:0]      acc_i,
  input  logic [ACC_W-1:0]      half_i,
  output logic                  busy_o,
  output logic [IDX_W-1:0]      bit_idx_o,
  output logic                  level_hi_o
);
  logic                  busy_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      frame_q <= frame_i;
    end else if (busy_q && tick_i) begin
      if (idx_q == IDX_W'(FRAME_BITS - 1)) busy_q <= 1'b0;
      else                                 idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    if (!busy_q)                          level_hi_o = 1'b0;
    else if (idx_q < IDX_W'(RUNIN_BITS))  level_hi_o = (acc_i < half_i);
    else                                  level_hi_o = frame_q[idx_q];
  end

  assign busy_o    = busy_q;
  assign bit_idx_o = idx_q;
endmodule

// File: rtl/cc21_line21_enc.sv
module cc21_line21_enc
  import cc21_pkg::*;
#(
  parameter int                 LINE_W    = 6,
  parameter int                 DLY_W     = 9,
  parameter int                 LEVEL_W   = 8,
  parameter logic [LEVEL_W-1:0] LOW_CODE  = 16,
  parameter logic [LEVEL_W-1:0] HIGH_CODE = 126,
  parameter int                 NTSC_CLKS = 1716,
  parameter int                 PAL_CLKS  = 1728,
  parameter int                 BIT_STEP  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_start_i,
  input  logic               field_id_i,
  input  logic               line_start_i,
  input  logic               mode50_i,
  input  logic [LINE_W-1:0]  line_sel_i,
  input  logic [DLY_W-1:0]   delay_i,
  input  logic [1:0]         field_en_i,
  input  logic               wr_en_i,
  input  logic               wr_field_i,
  input  logic [7:0]         wr_byte0_i,
  input  logic [7:0]         wr_byte1_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic               active_o
);
  localparam int MAX_CLKS = (PAL_CLKS > NTSC_CLKS) ? PAL_CLKS : NTSC_CLKS;
  localparam int ACC_W    = $clog2(MAX_CLKS) + 1;
  localparam int IDX_W    = $clog2(FRAME_BITS);
  localparam logic [CHAR_BITS-1:0] NULL_CHAR = with_odd_parity('0);

  logic                  start_w, cur_field_w, busy_w, bit_tick_w, level_hi_w;
  logic [IDX_W-1:0]      bit_idx_w;
  logic [ACC_W-1:0]      acc_w, period_w, half_w;
  logic [FRAME_BITS-1:0] frame_w;
  logic [CHAR_BITS-1:0]  tx_c0, tx_c1;
  logic [CHAR_BITS-1:0]  c0_q [2];
  logic [CHAR_BITS-1:0]  c1_q [2];
  logic                  fresh_q [2];

  assign period_w = mode50_i ? ACC_W'(PAL_CLKS) : ACC_W'(NTSC_CLKS);
  assign half_w   = period_w >> 1;

  for (genvar f = 0; f < 2; f++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c0_q[f]    <= NULL_CHAR;
        c1_q[f]    <= NULL_CHAR;
        fresh_q[f] <= 1'b0;
      end else if (wr_en_i && (wr_field_i == 1'(f))) begin
        c0_q[f]    <= with_odd_parity(wr_byte0_i);
        c1_q[f]    <= with_odd_parity(wr_byte1_i);
        fresh_q[f] <= 1'b1;
      end else if (start_w && (cur_field_w == 1'(f))) begin
        fresh_q[f] <= 1'b0;
      end
    end
  end

  always_comb begin
    tx_c0   = fresh_q[cur_field_w] ? c0_q[cur_field_w] : NULL_CHAR;
    tx_c1   = fresh_q[cur_field_w] ? c1_q[cur_field_w] : NULL_CHAR;
    frame_w = pack_frame(tx_c0, tx_c1);
  end

  cc21_line_sched #(.LINE_W(LINE_W), .DLY_W(DLY_W)) sched_i (
    .clk(clk), .rst_n(rst_n), .field_start_i(field_start_i), .field_id_i(field_id_i),
    .line_start_i(line_start_i), .line_sel_i(line_sel_i), .delay_i(delay_i),
    .field_en_i(field_en_i), .busy_i(busy_w), .start_o(start_w), .field_o(cur_field_w)
  );

  cc21_bit_timer #(.ACC_W(ACC_W), .STEP(BIT_STEP)) timer_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .run_i(busy_w),
    .period_i(period_w), .acc_o(acc_w), .tick_o(bit_tick_w)
  );

  cc21_serializer #(.ACC_W(ACC_W), .IDX_W(IDX_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .frame_i(frame_w), .tick_i(bit_tick_w),
    .acc_i(acc_w), .half_i(half_w), .busy_o(busy_w), .bit_idx_o(bit_idx_w),
    .level_hi_o(level_hi_w)
  );

  assign active_o = busy_w;
  assign level_o  = level_hi_w ? HIGH_CODE : LOW_CODE;
endmodule

// File: rtl/cc21_line21_chk.sv
module cc21_line21_chk
  import cc21_pkg::*;
#(
  parameter int                 LEVEL_W   = 8,
  parameter logic [LEVEL_W-1:0] LOW_CODE  = 16,
  parameter logic [LEVEL_W-1:0] HIGH_CODE = 126,
  parameter int                 IDX_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               active_o,
  input logic [LEVEL_W-1:0] level_o,
  input logic               start_w,
  input logic               bit_tick_w,
  input logic [IDX_W-1:0]   bit_idx_w
);
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> level_o == LOW_CODE);

  // R9
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (level_o == LOW_CODE || level_o == HIGH_CODE));

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> $past(start_w));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !bit_tick_w) |=> (active_o && $stable(bit_idx_w)));

  // R4
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && bit_tick_w && bit_idx_w == IDX_W'(FRAME_BITS - 1)) |=> !active_o);

  // R6
  framing_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && (bit_idx_w == IDX_W'(RUNIN_BITS) || bit_idx_w == IDX_W'(RUNIN_BITS + 1)))
    |-> level_o == LOW_CODE);

  // R6
  framing_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && bit_idx_w == IDX_W'(DATA_POS - 1)) |-> level_o == HIGH_CODE);
endmodule

bind cc21_line21_enc cc21_line21_chk #(
  .LEVEL_W(LEVEL_W), .LOW_CODE(LOW_CODE), .HIGH_CODE(HIGH_CODE), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .active_o(active_o), .level_o(level_o),
  .start_w(start_w), .bit_tick_w(bit_tick_w), .bit_idx_w(bit_idx_w)
);

// File: tb/cc21_line21_enc_tb_top.sv
`timescale 1ns/1ps
module cc21_line21_enc_tb_top;
  localparam logic [7:0] LOW  = 8'd16;
  localparam logic [7:0] HIGH = 8'd126;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_start = 0, field_id = 0, line_start = 0, mode50 = 0;
  logic [5:0] line_sel = 6'd3;
  logic [8:0] delay = 9'd10;
  logic [1:0] field_en = 2'b11;
  logic wr_en = 0, wr_field = 0;
  logic [7:0] wr_b0 = 0, wr_b1 = 0;
  logic [7:0] level;
  logic active;

  int checks = 0;
  int failures = 0;
  logic       m_fresh [2];
  logic [7:0] m_c0 [2];
  logic [7:0] m_c1 [2];

  always #2.5 clk = ~clk;

  cc21_line21_enc dut_i (
    .clk(clk), .rst_n(rst_n), .field_start_i(field_start), .field_id_i(field_id),
    .line_start_i(line_start), .mode50_i(mode50), .line_sel_i(line_sel), .delay_i(delay),
    .field_en_i(field_en), .wr_en_i(wr_en), .wr_field_i(wr_field), .wr_byte0_i(wr_b0),
    .wr_byte1_i(wr_b1), .level_o(level), .active_o(active)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input logic [7:0] raw);
    int ones = 0;
    for (int i = 0; i < 7; i++) ones += int'(raw[i]);
    return {(ones % 2 == 0) ? 1'b1 : 1'b0, raw[6:0]};
  endfunction

  task automatic write_pair(input logic f, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1; wr_field = f; wr_b0 = a; wr_b1 = b;
    @(negedge clk);
    wr_en = 0;
    m_fresh[f] = 1'b1; m_c0[f] = exp_char(a); m_c1[f] = exp_char(b);
  endtask

  // One line: strobe, then compare every cycle against the 32*t/N model.
  task automatic run_line(input bit expect_pkt, input logic [7:0] c0, input logic [7:0] c1);
    int n, d, t, k, ph;
    int bad_win, bad_run, bad_dat, bad_par, bad_idle;
    int a_win, e_win, a_dat, e_dat;
    logic e_act, e_hi;
    logic [25:0] fr;
    n = mode50 ? 1728 : 1716;
    d = int'(delay);
    fr = '0; fr[9] = 1'b1; fr[17:10] = c0; fr[25:18] = c1;
    bad_win = 0; bad_run = 0; bad_dat = 0; bad_par = 0; bad_idle = 0;
    a_win = 0; e_win = 0; a_dat = 0; e_dat = 0;
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
    for (int s = 0; s < n - 1; s++) begin
      t = s - (d + 1);
      k = (t >= 0) ? (32 * t) / n : -1;
      ph = (t >= 0) ? (32 * t) % n : 0;
      e_act = expect_pkt && t >= 0 && k < 26;
      e_hi = 1'b0;
      if (e_act) e_hi = (k < 7) ? (2 * ph < n) : fr[k];
      if (!expect_pkt) begin
        if (active || level != LOW) bad_idle++;
      end else begin
        if (active != e_act) begin
          if (bad_win == 0) begin a_win = int'(active); e_win = s; end
          bad_win++;
        end else if (e_act && level != (e_hi ? HIGH : LOW)) begin
          if (k < 7) bad_run++;
          else if (k == 17 || k == 25) bad_par++;
          else begin
            if (bad_dat == 0) begin a_dat = int'(level); e_dat = int'(e_hi ? HIGH : LOW); end
            bad_dat++;
          end
        end else if (!e_act && level != LOW) bad_win++;
      end
      @(negedge clk);
    end
    if (!expect_pkt) check(bad_idle == 0, "R2", "idle line active/level mismatch cycles", bad_idle, 0);
    else begin
      check(bad_win == 0, "R3/R4", "active window mismatch (first: active, at cycle)", a_win, e_win);
      check(bad_run == 0, "R5", "run-in level mismatch cycles", bad_run, 0);
      check(bad_dat == 0, "R6", "framing/data level (first mismatch)", a_dat, e_dat);
      check(bad_par == 0, "R7", "parity bit level mismatch cycles", bad_par, 0);
    end
  endtask

  task automatic run_field(input logic f, input int nlines, input string tag);
    logic [7:0] c0, c1;
    bit pkt;
    @(negedge clk); field_start = 1; field_id = f;
    @(negedge clk); field_start = 0;
    for (int l = 1; l <= nlines; l++) begin
      pkt = (l == int'(line_sel)) && field_en[f];
      c0 = m_fresh[f] ? m_c0[f] : 8'h80;
      c1 = m_fresh[f] ? m_c1[f] : 8'h80;
      if (pkt) begin
        m_fresh[f] = 1'b0;
        $display("%s field %0d line %0d chars %h %h", tag, f, l, c0, c1);
      end
      run_line(pkt, c0, c1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int f = 0; f < 2; f++) begin m_fresh[f] = 0; m_c0[f] = 8'h80; m_c1[f] = 8'h80; end
    repeat (3) @(negedge clk);
    check(active == 0 && level == LOW, "R1", "in reset active/level", int'(level), int'(LOW));
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(active == 0 && level == LOW, "R1", "after reset active/level", int'(level), int'(LOW));

    // written bit 7 deliberately wrong on both chars (R7)
    write_pair(1'b0, 8'h41, 8'h87);
    run_field(1'b0, 4, "R2 basic");
    run_field(1'b1, 4, "R8 never written");
    run_field(1'b0, 4, "R8 consumed");

    // R10: pair for a disabled field stays pending
    field_en = 2'b01;
    write_pair(1'b1, 8'h12, 8'h34);
    run_field(1'b1, 4, "R10 disabled");
    field_en = 2'b11;
    run_field(1'b1, 4, "R10 pending sent");

    // R4: 1728-clock lines, zero delay, line 2
    mode50 = 1; delay = 9'd0; line_sel = 6'd2;
    write_pair(1'b0, 8'h55, 8'hAA);
    run_field(1'b0, 3, "R4 50Hz");

    // R3: long delay on line 21
    mode50 = 0; delay = 9'd200; line_sel = 6'd21;
    write_pair(1'b0, 8'h7F, 8'h00);
    run_field(1'b0, 22, "R3 line21");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule